// File: doc/BRIEF.md
# SMBus Read Master

This block is a byte-level two-wire bus master for read transfers. On a start command it puts a START condition on the bus and sends the 7-bit target address with the direction bit set to read. It then clocks data bytes in from the target on SDA while it drives SCL. Both pins are open-drain: the block only ever pulls a line low (output enable high) and reads each line back through its own input.

After each received byte the block raises an interrupt and an acknowledge-request flag. This happens before the ninth clock, and SCL stays low until the host decides. A host ACK pulse with value 1 acknowledges the byte and the next byte follows. Value 0 sends NACK; together with a stop request it ends the read with a STOP condition. If the host writes a data byte while an acknowledge is pending, the block answers the pending byte with NACK and becomes a transmitter for the written byte. SCL timing comes from a programmable divider, and a target that holds SCL low stretches the high phase.

Top module: `smb_read_master`

## Requirements
- R1: After reset and whenever idle, both output enables are low and irq_o, ack_req_o and busy_o are low.
- R2: A start command produces SDA falling while SCL is high, then nine SCL pulses whose first eight carry the address MSB first followed by a 1 (read); the target's ACK is sampled on the ninth pulse.
- R3: SDA is sampled on the rising edge of SCL, MSB first, and the master changes SDA only while SCL is low except at START and STOP; a finished byte appears on rx_data_o.
- R4: After the eighth data bit of each received byte, irq_o and ack_req_o go high before the ninth pulse, SCL is held low with SDA released, and no further SCL pulse occurs until the host acts.
- R5: An ack_wr_i pulse with ack_val_i=1 drives SDA low on the ninth pulse; with ack_val_i=0 SDA stays released (NACK).
- R6: After an ACK the next data byte is clocked in at once, so any number of bytes can be read in one transfer.
- R7: A stop_req_i pulse while an acknowledge is pending makes the block, after sending the ninth bit, generate STOP (SDA rising while SCL high) and return to idle.
- R8: An address NACK sets addr_nack_o and irq_o with ack_req_o low, clocks no data bytes, ignores data_wr_i, and waits for stop_req_i to send STOP.
- R9: data_wr_i while an acknowledge is pending sets tx_mode_o on the next cycle, sends NACK for the pending byte, transmits the written byte MSB first, samples the target's ACK into slave_nack_o (1 = NACK) and then raises irq_o with ack_req_o low.
- R10: Each SCL low and high phase lasts div_i+1 clock cycles (div_i at least 1); while SCL is released but read back low, the high-phase count does not start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | SCL half-period minus one, in clock cycles |
| cmd_start_i | input | 1 | Pulse: begin a read transfer (ignored when busy) |
| slave_addr_i | input | DATA_W-1 | Target address |
| ack_wr_i | input | 1 | Pulse: host writes the acknowledge bit |
| ack_val_i | input | 1 | Acknowledge value, 1 = ACK, 0 = NACK |
| stop_req_i | input | 1 | Pulse: request STOP |
| data_wr_i | input | 1 | Pulse: host writes a byte to transmit |
| data_i | input | DATA_W | Byte to transmit |
| scl_i | input | 1 | SCL line as read back |
| sda_i | input | 1 | SDA line as read back |
| scl_oe_o | output | 1 | Pull SCL low |
| sda_oe_o | output | 1 | Pull SDA low |
| irq_o | output | 1 | Interrupt, high while the block waits for the host |
| ack_req_o | output | 1 | A received byte awaits ACK/NACK |
| busy_o | output | 1 | Transfer in progress |
| tx_mode_o | output | 1 | Master is transmitting |
| addr_nack_o | output | 1 | Address was not acknowledged |
| slave_nack_o | output | 1 | Last transmitted data byte was not acknowledged |
| rx_data_o | output | DATA_W | Last received byte |

## Verification
On every cycle the checker holds that a pending acknowledge keeps SCL pulled low with the interrupt up, that the pending request survives until the host writes an acknowledge or data, that an address NACK never coexists with a pending data byte, that a data write during a pending acknowledge switches to transmit mode, and that the idle bus is released. Bit values on the wire, the START/STOP shapes, byte order, the number of SCL pulses, phase lengths and the clock-stretch effect need a modelled target and bus monitor, so only the directed scenarios show them.

// File: rtl/smb_read_pkg.sv
package smb_read_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START_A,
    ST_START_B,
    ST_LO,
    ST_HI,
    ST_HOLD_RX,
    ST_HOLD,
    ST_STOP_A,
    ST_STOP_B,
    ST_STOP_C
  } smb_state_e;

  function automatic logic scl_released(input smb_state_e s);
    return (s == ST_IDLE) || (s == ST_START_A) || (s == ST_START_B) ||
           (s == ST_HI) || (s == ST_STOP_B) || (s == ST_STOP_C);
  endfunction

  function automatic logic phase_timed(input smb_state_e s);
    return (s != ST_IDLE) && (s != ST_HOLD_RX) && (s != ST_HOLD);
  endfunction
endpackage

// File: rtl/smb_read_tick.sv
module smb_read_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             stall_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i)             cnt_q <= '0;
    else if (stall_i)           cnt_q <= cnt_q;
    else if (cnt_q == div_i)    cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && !stall_i && (cnt_q == div_i);
endmodule

// File: rtl/smb_read_shreg.sv
module smb_read_shreg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (load_i)  q_o <= load_val_i;
    else if (shift_i) q_o <= {q_o[W-2:0], bit_i};
  end
endmodule

// File: rtl/smb_read_master.sv
module smb_read_master
  import smb_read_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              cmd_start_i,
  input  logic [DATA_W-2:0] slave_addr_i,
  input  logic              ack_wr_i,
  input  logic              ack_val_i,
  input  logic              stop_req_i,
  input  logic              data_wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              irq_o,
  output logic              ack_req_o,
  output logic              busy_o,
  output logic              tx_mode_o,
  output logic              addr_nack_o,
  output logic              slave_nack_o,
  output logic [DATA_W-1:0] rx_data_o
);
  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);
  localparam logic [BIT_W-1:0] ACK_BIT  = BIT_W'(DATA_W);

  smb_state_e        state_q;
  logic [BIT_W-1:0]  bit_q;
  logic              tx_q, is_addr_q, ack_val_q, stop_pend_q, switch_pend_q;
  logic              addr_nack_q, slave_nack_q, sda_q;
  logic [DATA_W-1:0] tx_byte_q, rx_data_q, sh_q;
  logic              tick, stall, scl_rel, sda_next;
  logic              sh_load, sh_shift;
  logic [DATA_W-1:0] sh_val;
  logic              hi_done, data_bit;

  assign scl_rel  = scl_released(state_q);
  assign stall    = scl_rel && !scl_i && (state_q != ST_IDLE);
  assign hi_done  = (state_q == ST_HI) && tick;
  assign data_bit = (bit_q < ACK_BIT);

  smb_read_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (phase_timed(state_q)),
    .stall_i (stall),
    .div_i   (div_i),
    .tick_o  (tick)
  );

  // Loads: address at start, host byte from hold, switched byte after the NACK bit
  always_comb begin
    sh_load = 1'b0;
    sh_val  = data_i;
    if (state_q == ST_IDLE && cmd_start_i) begin
      sh_load = 1'b1;
      sh_val  = {slave_addr_i, 1'b1};
    end else if (state_q == ST_HOLD && !stop_req_i && data_wr_i && !addr_nack_q) begin
      sh_load = 1'b1;
    end else if (hi_done && !data_bit && switch_pend_q && !stop_pend_q) begin
      sh_load = 1'b1;
      sh_val  = tx_byte_q;
    end
  end

  assign sh_shift = hi_done && data_bit;

  smb_read_shreg #(.W(DATA_W)) u_shreg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (sh_load),
    .load_val_i (sh_val),
    .shift_i    (sh_shift),
    .bit_i      (sda_i),
    .q_o        (sh_q)
  );

  always_comb begin
    unique case (state_q)
      ST_START_B, ST_STOP_A, ST_STOP_B: sda_next = 1'b1;
      ST_LO, ST_HI: begin
        if (data_bit) sda_next = tx_q ? !sh_q[DATA_W-1] : 1'b0;
        else          sda_next = tx_q ? 1'b0 : ack_val_q;
      end
      default: sda_next = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      bit_q         <= '0;
      tx_q          <= 1'b0;
      is_addr_q     <= 1'b0;
      ack_val_q     <= 1'b0;
      stop_pend_q   <= 1'b0;
      switch_pend_q <= 1'b0;
      addr_nack_q   <= 1'b0;
      slave_nack_q  <= 1'b0;
      tx_byte_q     <= '0;
      rx_data_q     <= '0;
      sda_q         <= 1'b0;
    end else begin
      sda_q <= sda_next;  // one cycle behind SCL so SDA never moves on an SCL edge
      unique case (state_q)
        ST_IDLE: if (cmd_start_i) begin
          state_q       <= ST_START_A;
          tx_q          <= 1'b1;
          is_addr_q     <= 1'b1;
          bit_q         <= '0;
          addr_nack_q   <= 1'b0;
          slave_nack_q  <= 1'b0;
          stop_pend_q   <= 1'b0;
          switch_pend_q <= 1'b0;
        end
        ST_START_A: if (tick) state_q <= ST_START_B;
        ST_START_B: if (tick) state_q <= ST_LO;
        ST_LO:      if (tick) state_q <= ST_HI;
        ST_HI: if (tick) begin
          if (data_bit) begin
            bit_q <= bit_q + 1'b1;
            if (!tx_q && bit_q == LAST_BIT) begin
              rx_data_q <= {sh_q[DATA_W-2:0], sda_i};
              state_q   <= ST_HOLD_RX;
            end else begin
              state_q <= ST_LO;
            end
          end else begin
            bit_q     <= '0;
            is_addr_q <= 1'b0;
            if (stop_pend_q) begin
              state_q <= ST_STOP_A;
            end else if (switch_pend_q) begin
              switch_pend_q <= 1'b0;
              tx_q          <= 1'b1;
              state_q       <= ST_LO;
            end else if (tx_q && is_addr_q) begin
              if (!sda_i) begin
                tx_q    <= 1'b0;
                state_q <= ST_LO;
              end else begin
                addr_nack_q <= 1'b1;
                state_q     <= ST_HOLD;
              end
            end else if (tx_q) begin
              slave_nack_q <= sda_i;
              state_q      <= ST_HOLD;
            end else begin
              state_q <= ack_val_q ? ST_LO : ST_HOLD;
            end
          end
        end
        ST_HOLD_RX: begin
          if (stop_req_i) stop_pend_q <= 1'b1;
          if (data_wr_i) begin
            switch_pend_q <= 1'b1;
            tx_q          <= 1'b1;
            tx_byte_q     <= data_i;
            ack_val_q     <= 1'b0;
            state_q       <= ST_LO;
          end else if (ack_wr_i) begin
            ack_val_q <= ack_val_i;
            state_q   <= ST_LO;
          end
        end
        ST_HOLD: begin
          if (stop_req_i) begin
            state_q <= ST_STOP_A;
          end else if (data_wr_i && !addr_nack_q) begin
            tx_q         <= 1'b1;
            bit_q        <= '0;
            slave_nack_q <= 1'b0;
            state_q      <= ST_LO;
          end
        end
        ST_STOP_A: if (tick) state_q <= ST_STOP_B;
        ST_STOP_B: if (tick) state_q <= ST_STOP_C;
        ST_STOP_C: if (tick) state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign scl_oe_o     = !scl_rel;
  assign sda_oe_o     = sda_q;
  assign irq_o        = (state_q == ST_HOLD_RX) || (state_q == ST_HOLD);
  assign ack_req_o    = (state_q == ST_HOLD_RX);
  assign busy_o       = (state_q != ST_IDLE);
  assign tx_mode_o    = tx_q && busy_o;
  assign addr_nack_o  = addr_nack_q;
  assign slave_nack_o = slave_nack_q;
  assign rx_data_o    = rx_data_q;
endmodule

// File: rtl/smb_read_master_chk.sv
module smb_read_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ack_wr_i,
  input logic data_wr_i,
  input logic scl_oe_o,
  input logic sda_oe_o,
  input logic irq_o,
  input logic ack_req_o,
  input logic busy_o,
  input logic tx_mode_o,
  input logic addr_nack_o
);
  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!scl_oe_o && !sda_oe_o && !irq_o)); // R1

  AST_ACKREQ_HOLDS_SCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_req_o |-> (scl_oe_o && irq_o && busy_o)); // R4

  AST_ACKREQ_WAITS_HOST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_req_o && !ack_wr_i && !data_wr_i) |=> ack_req_o); // R4

  AST_ADDR_NACK_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_nack_o |-> !ack_req_o); // R8

  AST_DATA_WR_SWITCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_req_o && data_wr_i) |=> (tx_mode_o && !ack_req_o)); // R9
endmodule

bind smb_read_master smb_read_master_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ack_wr_i    (ack_wr_i),
  .data_wr_i   (data_wr_i),
  .scl_oe_o    (scl_oe_o),
  .sda_oe_o    (sda_oe_o),
  .irq_o       (irq_o),
  .ack_req_o   (ack_req_o),
  .busy_o      (busy_o),
  .tx_mode_o   (tx_mode_o),
  .addr_nack_o (addr_nack_o)
);

// File: tb/smb_read_master_bench.sv
module smb_read_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 3;
  localparam int STRETCH_CYC = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div = 8'(DIV);
  logic       cmd_start = 0, ack_wr = 0, ack_val = 0, stop_req = 0, data_wr = 0;
  logic [6:0] slave_addr = '0;
  logic [7:0] data = '0;
  logic       scl_oe, sda_oe, irq, ack_req, busy, tx_mode, addr_nack, slave_nack;
  logic [7:0] rx_data;

  logic slv_sda = 0, stretch = 0, slv_done = 0, slv_addr_ack = 1, slv_ack_tx = 1;
  logic [7:0] slv_data [4];
  int   slv_rx_from = 99, stretch_at = -1;
  wire  scl_line = !scl_oe && !stretch;
  wire  sda_line = !(sda_oe || slv_sda);

  int  rise_cnt = 0, starts = 0, stops = 0;
  logic mon_bits [64];
  time rise_t [64];
  time fall_t [64];
  int  checks = 0, fails = 0;
  bit  done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_read_master u_smb_read_master (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div), .cmd_start_i(cmd_start),
    .slave_addr_i(slave_addr), .ack_wr_i(ack_wr), .ack_val_i(ack_val),
    .stop_req_i(stop_req), .data_wr_i(data_wr), .data_i(data),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .irq_o(irq), .ack_req_o(ack_req), .busy_o(busy), .tx_mode_o(tx_mode),
    .addr_nack_o(addr_nack), .slave_nack_o(slave_nack), .rx_data_o(rx_data)
  );

  // Bus monitor
  always @(negedge sda_line) if (scl_line === 1'b1) begin
    starts++; rise_cnt = 0; slv_sda = 0; slv_done = 0;
  end
  always @(posedge sda_line) if (scl_line === 1'b1) stops++;
  always @(posedge scl_line) begin
    if (rise_cnt < 64) begin
      mon_bits[rise_cnt] = sda_line;
      rise_t[rise_cnt] = $time;
      if (rise_cnt % 9 == 8 && rise_cnt / 9 > 0 && rise_cnt / 9 < slv_rx_from && sda_line)
        slv_done = 1;
    end
    rise_cnt++;
  end
  // Target model: drives only while SCL is low
  always @(negedge scl_line) begin
    int b, by, pos;
    b = rise_cnt; by = b / 9; pos = b % 9;
    if (b < 64) fall_t[b] = $time;
    slv_sda = 0;
    if (pos == 8)
      slv_sda = (by == 0) ? slv_addr_ack : (by >= slv_rx_from && slv_ack_tx);
    else if (by > 0 && by < slv_rx_from && slv_addr_ack && !slv_done && by <= 4)
      slv_sda = !slv_data[by-1][7-pos];
  end
  always @(negedge scl_line) if (rise_cnt == stretch_at) begin
    stretch = 1;
    repeat (STRETCH_CYC) @(negedge clk);
    stretch = 0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mon_byte(input int base);
    logic [7:0] v = '0;
    for (int i = 0; i < 8; i++) v = {v[6:0], mon_bits[base+i]};
    return v;
  endfunction

  task automatic wait_irq();
    int n = 0;
    while (!irq && n < 5000) begin @(negedge clk); n++; end
  endtask
  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
  endtask
  task automatic begin_read(input logic [6:0] a);
    starts = 0; stops = 0;
    @(negedge clk); slave_addr = a; cmd_start = 1;
    @(negedge clk); cmd_start = 0;
  endtask
  task automatic host_ack(input logic v, input logic stop);
    @(negedge clk); ack_val = v; ack_wr = 1; stop_req = stop;
    @(negedge clk); ack_wr = 0; stop_req = 0;
  endtask
  task automatic host_stop();
    @(negedge clk); stop_req = 1;
    @(negedge clk); stop_req = 0;
  endtask
  task automatic host_data(input logic [7:0] d);
    @(negedge clk); data = d; data_wr = 1;
    @(negedge clk); data_wr = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 scl_oe", 32'(scl_oe), 0);
    chk("R1 sda_oe", 32'(sda_oe), 0);
    chk("R1 irq/ack_req/busy", {29'd0, irq, ack_req, busy}, 0);
  endtask

  task automatic t_read_three();
    slv_addr_ack = 1; slv_rx_from = 99;
    slv_data[0] = 8'hA5; slv_data[1] = 8'h3C; slv_data[2] = 8'hF0; slv_data[3] = 8'h00;
    begin_read(7'h5A);
    wait_irq();
    chk("R2 start seen", 32'(starts), 1);
    chk("R2 address byte", 32'(mon_byte(0)), 32'h5A << 1 | 1);
    chk("R2 address ack", 32'(mon_bits[8]), 0);
    chk("R3 first byte", 32'(rx_data), 32'hA5);
    chk("R4 irq before ninth clock", 32'(rise_cnt), 17);
    chk("R4 hold state", {29'd0, ack_req, scl_oe, sda_oe}, 3'b110);
    chk("R10 bit period", 32'(rise_t[3] - rise_t[2]), 2 * (DIV + 1) * CLK_PERIOD);
    chk("R10 high time", 32'(fall_t[3] - rise_t[2]), (DIV + 1) * CLK_PERIOD);
    repeat (30) @(negedge clk);
    chk("R4 stalled pulses", 32'(rise_cnt), 17);
    chk("R4 still pending", 32'(ack_req), 1);
    host_ack(1, 0);
    wait_irq();
    chk("R5 ack driven low", 32'(mon_bits[17]), 0);
    chk("R6 second byte", 32'(rx_data), 32'h3C);
    chk("R6 pulse count", 32'(rise_cnt), 26);
    host_ack(1, 0);
    wait_irq();
    chk("R6 third byte", 32'(rx_data), 32'hF0);
    host_ack(0, 1);
    wait_idle();
    chk("R5 nack released", 32'(mon_bits[35]), 1);
    chk("R7 stop seen", 32'(stops), 1);
    chk("R7 pulses incl stop", 32'(rise_cnt), 37);
    @(negedge clk);
    chk("R1 idle after stop", {28'd0, busy, irq, scl_oe, sda_oe}, 0);
  endtask

  task automatic t_stretch();
    slv_addr_ack = 1; slv_rx_from = 99; slv_data[0] = 8'h96;
    stretch_at = 3;
    begin_read(7'h21);
    wait_irq();
    stretch_at = -1;
    chk("R10 stretched high time", 32'(fall_t[4] - rise_t[3]),
        (DIV + 1) * CLK_PERIOD - CLK_PERIOD / 2);
    chk("R10 stretched address intact", 32'(mon_byte(0)), 32'h43);
    chk("R3 byte after stretch", 32'(rx_data), 32'h96);
    host_ack(0, 1);
    wait_idle();
    chk("R7 stop after stretch", 32'(stops), 1);
  endtask

  task automatic t_addr_nack();
    slv_addr_ack = 0; slv_rx_from = 99;
    begin_read(7'h33);
    wait_irq();
    chk("R8 addr_nack", 32'(addr_nack), 1);
    chk("R8 no ack request", 32'(ack_req), 0);
    chk("R8 nine pulses", 32'(rise_cnt), 9);
    host_data(8'h55);
    repeat (30) @(negedge clk);
    chk("R8 data write ignored", 32'(rise_cnt), 9);
    chk("R8 still waiting", {30'd0, irq, scl_oe}, 2'b11);
    host_stop();
    wait_idle();
    chk("R8 stop sent", 32'(stops), 1);
    slv_addr_ack = 1;
  endtask

  task automatic t_switch();
    slv_addr_ack = 1; slv_rx_from = 2; slv_ack_tx = 1; slv_data[0] = 8'h81;
    begin_read(7'h0F);
    wait_irq();
    chk("R3 byte before switch", 32'(rx_data), 32'h81);
    @(negedge clk); data = 8'hC6; data_wr = 1;
    @(negedge clk); data_wr = 0;
    chk("R9 tx_mode set", 32'(tx_mode), 1);
    wait_irq();
    chk("R9 pending byte nacked", 32'(mon_bits[17]), 1);
    chk("R9 transmitted byte", 32'(mon_byte(18)), 32'hC6);
    chk("R9 target ack seen", 32'(slave_nack), 0);
    chk("R9 irq without ack_req", {30'd0, irq, ack_req}, 2'b10);
    chk("R9 pulse count", 32'(rise_cnt), 27);
    host_stop();
    wait_idle();
    chk("R9 stop after tx", 32'(stops), 1);
    slv_rx_from = 99;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_read_three();
    t_stretch();
    t_addr_nack();
    t_switch();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule